// File: doc/BRIEF.md
# Serial Isolation Responder

This block plays the card's part in a serial isolation round on a shared, wired-OR data bus. A card identifier of 64 bits is extended with an 8-bit checksum to form a 72-bit sequence. The host reads the isolation register twice for every bit. If the card's current bit is 1, the card answers the first read of the pair with 0x55 and the second with 0xAA. If the bit is 0, the card keeps off the bus and listens instead.

A card whose bit is 0 and which senses another card's 0x55 followed by 0xAA in the same pair has lost arbitration. It drops out and goes quiet until the next wake. A card that reaches the end of all 72 bits without dropping out is the isolated winner. It holds that flag and waits for the next step of configuration, which is handled outside this block.

A wake command with data zero starts a fresh round. It also returns the bit pointer and the checksum register to their start values. The host side decodes the read port address and the wake command into the single-cycle strobes this block takes.

Top module: `iso_responder`

## Requirements
- R1: After synchronous reset the block is asleep: `dout_en` is 0, `dout` is 0x00, and both `iso_winner` and `iso_lost` are 0.
- R2: While asleep (after reset, after losing, or after winning), isolation read strobes produce no drive: `dout_en` stays 0 and `dout` stays 0x00.
- R3: A `wake_zero` pulse starts a round. It clears `iso_winner` and `iso_lost`, sets the bit pointer to bit 0, sets the pair phase to the first read, and loads the checksum register with 0x6A. This holds even when a round is already in progress.
- R4: In the cycle after an accepted read strobe, `dout_en` equals the card's current bit. When that bit is 1, `dout` is 0x55 for the first read of a pair and 0xAA for the second. When the bit is 0, `dout` is 0x00. `dout_en` is high for exactly one cycle per read.
- R5: Sequence bits 0 to 63 are `card_id[0]` to `card_id[63]`, in that order. This sends byte 0 first, and each byte least significant bit first.
- R6: Sequence bits 64 to 71 are the checksum, sent least significant bit first. The checksum register starts at 0x6A. After each of the first 64 bits it becomes {old[0] ^ old[1] ^ bit, old[7:1]}.
- R7: If the card's bit is 0, it senses 0x55 on the bus in the first response cycle of the pair, and it senses 0xAA in the second, then `iso_lost` rises and the card stops responding. A card whose bit is 1 never loses, whatever else is on the bus.
- R8: Sensing only one half of the pattern (0x55 without a following 0xAA) does not cause a loss.
- R9: When bit 71 completes without a loss, `iso_winner` rises and stays high until the next `wake_zero`. `iso_winner` and `iso_lost` are never high together.
- R10: A read strobe that arrives in the response cycle of the previous read is ignored. It neither produces a drive nor advances the pair phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_zero | input | 1 | One-cycle pulse: wake command with data zero |
| iso_rd | input | 1 | One-cycle pulse: host read of the isolation register |
| bus_din | input | 8 | Data sensed on the shared bus |
| card_id | input | ID_BITS | Card identifier, bit 0 sent first |
| dout | output | 8 | Byte driven onto the bus |
| dout_en | output | 1 | Bus drive enable for `dout` |
| iso_winner | output | 1 | Card completed isolation without losing |
| iso_lost | output | 1 | Card lost arbitration in this round |

## Verification
The bench builds the block with its defaults: a 64-bit identifier and an 8-bit checksum. With these values it runs full 72-bit rounds on seeded random identifiers, so every checksum bit is compared against a bench-side model of the register. A competitor is modelled as extra data ORed onto the bus. This places the loss, the half-pattern non-loss and the collision on a 1 bit at chosen bit positions. A wake in the middle of a round and a back-to-back strobe exercise the restart and the ignored-read paths.

// File: rtl/iso_pkg.sv
package iso_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP   = 2'd0,
    ST_ISOLATE = 2'd1,
    ST_WON     = 2'd2
  } iso_state_e;

  localparam logic [7:0] PAT_FIRST  = 8'h55;
  localparam logic [7:0] PAT_SECOND = 8'hAA;
endpackage

// File: rtl/iso_cksum_lfsr.sv
module iso_cksum_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] SEED = 8'h6A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         step,
  input  logic         bit_in,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst || init) begin
      value <= SEED;
    end else if (step) begin
      value <= {value[0] ^ value[1] ^ bit_in, value[W-1:1]};
    end
  end
endmodule

// File: rtl/iso_bit_pointer.sv
module iso_bit_pointer #(
  parameter int ID_BITS = 64,
  parameter int CK_BITS = 8,
  localparam int TOTAL = ID_BITS + CK_BITS,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init,
  input  logic               advance,
  input  logic [ID_BITS-1:0] card_id,
  input  logic [CK_BITS-1:0] cksum,
  output logic               cur_bit,
  output logic               in_id_field,
  output logic               last_bit
);
  logic [IDX_W-1:0] idx;
  logic [TOTAL-1:0] seq;

  assign seq         = {cksum, card_id};
  assign cur_bit     = seq[idx];
  assign in_id_field = (idx < IDX_W'(ID_BITS));
  assign last_bit    = (idx == IDX_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst || init) begin
      idx <= '0;
    end else if (advance && !last_bit) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/iso_pair_io.sv
module iso_pair_io (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       accept,
  input  logic       cur_bit,
  input  logic [7:0] bus_din,
  output logic [7:0] dout,
  output logic       dout_en,
  output logic       resp_vld,
  output logic       resp_second,
  output logic       pair_sensed
);
  import iso_pkg::*;

  logic phase;
  logic saw_first;

  assign pair_sensed = saw_first && (bus_din == PAT_SECOND);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase       <= 1'b0;
      saw_first   <= 1'b0;
      resp_vld    <= 1'b0;
      resp_second <= 1'b0;
      dout        <= 8'h00;
      dout_en     <= 1'b0;
    end else begin
      resp_vld <= 1'b0;
      dout_en  <= 1'b0;
      dout     <= 8'h00;
      if (accept) begin
        resp_vld    <= 1'b1;
        resp_second <= phase;
        phase       <= ~phase;
        dout_en     <= cur_bit;
        if (cur_bit) dout <= phase ? PAT_SECOND : PAT_FIRST;
      end
      if (resp_vld && !resp_second) begin
        saw_first <= (bus_din == PAT_FIRST);
      end
    end
  end
endmodule

// File: rtl/iso_responder.sv
module iso_responder #(
  parameter int ID_BITS = 64,
  parameter int CK_BITS = 8,
  parameter logic [CK_BITS-1:0] CK_SEED = 8'h6A
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wake_zero,
  input  logic               iso_rd,
  input  logic [7:0]         bus_din,
  input  logic [ID_BITS-1:0] card_id,
  output logic [7:0]         dout,
  output logic               dout_en,
  output logic               iso_winner,
  output logic               iso_lost
);
  import iso_pkg::*;

  iso_state_e state;
  logic [CK_BITS-1:0] cksum;
  logic cur_bit, in_id_field, last_bit;
  logic resp_vld, resp_second, pair_sensed;
  logic accept, pair_done, lose_now, advance;

  assign accept    = (state == ST_ISOLATE) && iso_rd && !resp_vld && !wake_zero;
  assign pair_done = (state == ST_ISOLATE) && resp_vld && resp_second && !wake_zero;
  assign lose_now  = pair_done && !cur_bit && pair_sensed;
  assign advance   = pair_done && !lose_now;

  iso_cksum_lfsr #(.W(CK_BITS), .SEED(CK_SEED)) u_cksum (
    .clk(clk), .rst(rst), .init(wake_zero),
    .step(advance && in_id_field), .bit_in(cur_bit), .value(cksum)
  );

  iso_bit_pointer #(.ID_BITS(ID_BITS), .CK_BITS(CK_BITS)) u_ptr (
    .clk(clk), .rst(rst), .init(wake_zero), .advance(advance),
    .card_id(card_id), .cksum(cksum), .cur_bit(cur_bit),
    .in_id_field(in_id_field), .last_bit(last_bit)
  );

  iso_pair_io u_io (
    .clk(clk), .rst(rst), .clear(wake_zero), .accept(accept),
    .cur_bit(cur_bit), .bus_din(bus_din), .dout(dout), .dout_en(dout_en),
    .resp_vld(resp_vld), .resp_second(resp_second), .pair_sensed(pair_sensed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SLEEP;
      iso_winner <= 1'b0;
      iso_lost   <= 1'b0;
    end else if (wake_zero) begin
      state      <= ST_ISOLATE;
      iso_winner <= 1'b0;
      iso_lost   <= 1'b0;
    end else if (lose_now) begin
      state    <= ST_SLEEP;
      iso_lost <= 1'b1;
    end else if (advance && last_bit) begin
      state      <= ST_WON;
      iso_winner <= 1'b1;
    end
  end
endmodule

// File: rtl/iso_responder_chk.sv
module iso_responder_chk (
  input logic       clk,
  input logic       rst,
  input logic       wake_zero,
  input logic [7:0] dout,
  input logic       dout_en,
  input logic       iso_winner,
  input logic       iso_lost
);
  assert_pattern_R4: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> (dout == 8'h55 || dout == 8'hAA));
  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    dout_en |=> !dout_en);
  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == 8'h00));
  assert_wake_clears_R3: assert property (@(posedge clk) disable iff (rst)
    wake_zero |=> (!iso_winner && !iso_lost));
  assert_lost_silent_R7: assert property (@(posedge clk) disable iff (rst)
    iso_lost |-> !dout_en);
  assert_winner_silent_R9: assert property (@(posedge clk) disable iff (rst)
    iso_winner |-> !dout_en);
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(iso_winner && iso_lost));
  assert_winner_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (iso_winner && !wake_zero) |=> iso_winner);
endmodule

bind iso_responder iso_responder_chk u_chk (
  .clk(clk), .rst(rst), .wake_zero(wake_zero), .dout(dout),
  .dout_en(dout_en), .iso_winner(iso_winner), .iso_lost(iso_lost)
);

// File: tb/iso_responder_test.sv
module iso_responder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wake_zero = 1'b0;
  logic        iso_rd = 1'b0;
  logic [7:0]  other_drv = 8'h00;
  logic [63:0] card_id = '0;
  logic [7:0]  dout;
  logic        dout_en;
  logic        iso_winner, iso_lost;
  logic [7:0]  bus_din;
  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign bus_din = (dout_en ? dout : 8'h00) | other_drv;

  iso_responder uut (
    .clk(clk), .rst(rst), .wake_zero(wake_zero), .iso_rd(iso_rd),
    .bus_din(bus_din), .card_id(card_id), .dout(dout), .dout_en(dout_en),
    .iso_winner(iso_winner), .iso_lost(iso_lost)
  );

  function automatic logic [71:0] expect_seq(input logic [63:0] id);
    logic [7:0] ck = 8'h6A;
    for (int i = 0; i < 64; i++) ck = {ck[0] ^ ck[1] ^ id[i], ck[7:1]};
    return {ck, id};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wake();
    @(negedge clk); other_drv = 8'h00; wake_zero = 1'b1;
    @(negedge clk); wake_zero = 1'b0;
  endtask

  // one read; returns what the card put on the bus in its response cycle
  task automatic do_read(input logic [7:0] drv, output logic en, output logic [7:0] d);
    @(negedge clk); other_drv = 8'h00; iso_rd = 1'b1;
    @(negedge clk); iso_rd = 1'b0; other_drv = drv;
    en = dout_en; d = dout;
  endtask

  task automatic do_bit(input string req, input logic expb, input logic [7:0] d1, input logic [7:0] d2);
    logic en; logic [7:0] d;
    do_read(d1, en, d);
    check(req, {23'd0, en, d}, {23'd0, expb, expb ? 8'h55 : 8'h00});
    do_read(d2, en, d);
    check(req, {23'd0, en, d}, {23'd0, expb, expb ? 8'hAA : 8'h00});
  endtask

  task automatic run_bits(input int from, input int to, input logic [71:0] sq);
    for (int i = from; i < to; i++)
      do_bit((i < 64) ? "R5" : "R6", sq[i], 8'h00, 8'h00);
  endtask

  task automatic settle();
    @(negedge clk); other_drv = 8'h00;
  endtask

  initial begin
    logic [71:0] sq;
    logic en; logic [7:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", {22'd0, dout_en, iso_winner, iso_lost, dout},
          {22'd0, 1'b0, 1'b0, 1'b0, 8'h00});

    // R2: reads while asleep
    card_id = 64'hFFFF_FFFF_FFFF_FFFF;
    do_read(8'h00, en, d); check("R2 asleep", {23'd0, en, d}, 32'd0);
    do_read(8'h00, en, d); check("R2 asleep", {23'd0, en, d}, 32'd0);

    // R4 R5 R6 R9: full rounds on random identifiers
    for (int r = 0; r < 3; r++) begin
      card_id = {$urandom(), $urandom()};
      sq = expect_seq(card_id);
      wake();
      run_bits(0, 72, sq);
      settle();
      check("R9 winner", {30'd0, iso_winner, iso_lost}, {30'd0, 1'b1, 1'b0});
      do_read(8'h00, en, d); check("R9 silent after win", {23'd0, en, d}, 32'd0);
      settle();
      check("R9 winner held", {31'd0, iso_winner}, 32'd1);
    end

    // R3: wake mid-round restarts pointer and checksum
    card_id = {$urandom(), $urandom()};
    sq = expect_seq(card_id);
    wake();
    check("R3 flags cleared", {30'd0, iso_winner, iso_lost}, 32'd0);
    run_bits(0, 20, sq);
    do_read(8'h00, en, d);          // leave a pair half done
    wake();
    run_bits(0, 72, sq);
    settle();
    check("R3 restart then win", {31'd0, iso_winner}, 32'd1);

    // R7: loss on a 0 bit at position 5
    card_id = {$urandom(), $urandom()};
    card_id[5] = 1'b0;
    sq = expect_seq(card_id);
    wake();
    run_bits(0, 5, sq);
    do_bit("R7 own bit zero", 1'b0, 8'h55, 8'hAA);
    settle();
    check("R7 lost", {30'd0, iso_winner, iso_lost}, {30'd0, 1'b0, 1'b1});
    do_read(8'h00, en, d); check("R7 silent after loss", {23'd0, en, d}, 32'd0);
    do_read(8'h00, en, d); check("R2 silent after loss", {23'd0, en, d}, 32'd0);

    // R8: half pattern on a 0 bit; R7: collision on a 1 bit
    card_id = {$urandom(), $urandom()};
    card_id[3] = 1'b0;
    card_id[9] = 1'b1;
    sq = expect_seq(card_id);
    wake();
    run_bits(0, 3, sq);
    do_bit("R8 half pattern", 1'b0, 8'h55, 8'h00);
    settle();
    check("R8 not lost", {31'd0, iso_lost}, 32'd0);
    run_bits(4, 9, sq);
    do_bit("R7 one bit collision", 1'b1, 8'h55, 8'hAA);
    settle();
    check("R7 one bit keeps going", {31'd0, iso_lost}, 32'd0);
    run_bits(10, 72, sq);
    settle();
    check("R8 win after half pattern", {30'd0, iso_winner, iso_lost}, {30'd0, 1'b1, 1'b0});

    // R10: strobe held into the response cycle
    card_id = {$urandom(), $urandom()};
    card_id[0] = 1'b1;
    sq = expect_seq(card_id);
    wake();
    @(negedge clk); iso_rd = 1'b1;
    @(negedge clk);
    check("R10 first response", {23'd0, dout_en, dout}, {23'd0, 1'b1, 8'h55});
    @(negedge clk); iso_rd = 1'b0;
    check("R10 extra strobe ignored", {23'd0, dout_en, dout}, 32'd0);
    do_read(8'h00, en, d);
    check("R10 phase kept", {23'd0, en, d}, {23'd0, 1'b1, 8'hAA});
    run_bits(1, 72, sq);
    settle();
    check("R10 win", {31'd0, iso_winner}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule